// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Decoder

This block turns two hard-limited square waves into a keypad code. One wave carries the low (row) tone of a keypad pair and the other carries the high (column) tone. Each wave is brought into the clock domain, and the block counts clock cycles between its rising edges. The counts from several consecutive periods are summed. The sum is then compared against four acceptance windows, one for each nominal tone of that group.

The valid flag is high only while both groups hold a recognised tone. While it is high, the code output gives the 4-bit key value of the row and column pair. If either wave stops toggling for longer than about two of its longest expected periods, that group drops out, and the flag falls.

The timebase frequency is a parameter. Its default is the 3.579545 MHz crystal rate, and all windows and timeouts are derived from it.

Top module: `dtmf_freq_decoder`

## Requirements
- R1: While reset is asserted and after its release with no input toggling, `early_valid` is 0 and `code` is 4'b0000.
- R2: A low-group wave at a nominal row tone (697, 770, 852 or 941 Hz, row index 0..3 in that order) is recognised as that row.
- R3: A high-group wave at a nominal column tone (1209, 1336, 1477 or 1633 Hz, column index 0..3 in that order) is recognised as that column.
- R4: A tone that deviates from its nominal value by up to 1.5% + 2 Hz is still accepted.
- R5: A tone that deviates from its nominal value by 3.5% or more is rejected, and `early_valid` stays 0.
- R6: The code map is as follows. Row r with column c<3 and r<3 gives 3r+c+1 (keys 1 to 9). Row 3 gives 4'b1011 with column 0, 4'b1010 with column 1 and 4'b1100 with column 2. Column 3 gives 4'b1101, 4'b1110 and 4'b1111 for rows 0, 1 and 2, and 4'b0000 for row 3.
- R7: `early_valid` is 1 only while both groups hold a recognised tone. A single tone alone keeps it at 0.
- R8: When a wave has no rising edge for the group timeout (two periods of the group's lowest tone at -2.5%), that group is cleared and `early_valid` falls.
- R9: `code` changes only while both groups are recognised, so it keeps the last valid key after `early_valid` falls.
- R10: The period is averaged over AVG_PERIODS periods. A single period stretched by about 6% inside an otherwise nominal tone does not drop `early_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_sq | input | 1 | Limited low-group (row) square wave, asynchronous |
| hi_sq | input | 1 | Limited high-group (column) square wave, asynchronous |
| early_valid | output | 1 | Both groups currently hold a recognised tone |
| code | output | 4 | Key code of the last recognised pair |

## Verification
The bench steps through every keypad pair and then tests tones pushed just inside the accept limit and just beyond the reject limit. A window set too tight would drop keys in the deviated cases. A window set too loose would accept a tone 4% off nominal.

It then silences one group mid-key. A timeout that is too short clears the flag early, and a missing timeout holds it high forever. After the flag falls, the bench checks that `code` still holds the last key.

A single stretched period checks the averaging. A decoder that judged each period on its own would pulse the flag low.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal tone of group grp (0 = row, 1 = column), index 0..3
  function automatic int unsigned nominal_hz(input bit grp, input logic [1:0] idx);
    if (grp == 1'b0) begin
      case (idx)
        2'd0: return 697;
        2'd1: return 770;
        2'd2: return 852;
        default: return 941;
      endcase
    end else begin
      case (idx)
        2'd0: return 1209;
        2'd1: return 1336;
        2'd2: return 1477;
        default: return 1633;
      endcase
    end
  endfunction

  // Smallest period sum accepted: tone at +2.5 %
  function automatic longint unsigned sum_min(input int unsigned clk_hz,
                                              input int unsigned avg,
                                              input int unsigned f_hz);
    return (longint'(avg) * longint'(clk_hz) * 1000) / (longint'(f_hz) * 1025);
  endfunction

  // Largest period sum accepted: tone at -2.5 %
  function automatic longint unsigned sum_max(input int unsigned clk_hz,
                                              input int unsigned avg,
                                              input int unsigned f_hz);
    return (longint'(avg) * longint'(clk_hz) * 1000) / (longint'(f_hz) * 975);
  endfunction

  // Silence limit: two periods of the lowest tone at -2.5 %
  function automatic int unsigned timeout_cyc(input int unsigned clk_hz,
                                              input int unsigned f_hz);
    return int'((longint'(clk_hz) * 2000) / (longint'(f_hz) * 975)) + 1;
  endfunction

  // Returns {hit, index}
  function automatic logic [2:0] classify(input longint unsigned sum,
                                          input int unsigned clk_hz,
                                          input int unsigned avg,
                                          input bit grp);
    logic [2:0] res;
    res = 3'b000;
    for (int i = 0; i < 4; i++) begin
      if (sum >= sum_min(clk_hz, avg, nominal_hz(grp, 2'(i))) &&
          sum <= sum_max(clk_hz, avg, nominal_hz(grp, 2'(i))))
        res = {1'b1, 2'(i)};
    end
    return res;
  endfunction

  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    if (col == 2'd3) begin
      return (row == 2'd3) ? 4'd0 : 4'(13 + int'(row));
    end else if (row == 2'd3) begin
      case (col)
        2'd0: return 4'd11;
        2'd1: return 4'd10;
        default: return 4'd12;
      endcase
    end else begin
      return 4'(3 * int'(row) + int'(col) + 1);
    end
  endfunction

endpackage

// File: rtl/dtmf_sync_edge.sv
module dtmf_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], sq_i};
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned AVG_PERIODS = 4,
  parameter bit          GRP         = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  output logic       tone_ok_o,
  output logic [1:0] tone_idx_o
);
  import dtmf_pkg::*;

  localparam int unsigned TIMEOUT = timeout_cyc(CLK_HZ, nominal_hz(GRP, 2'd0));
  localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1);
  localparam int unsigned ACC_W   = $clog2(AVG_PERIODS * (TIMEOUT + 1) + 1);
  localparam int unsigned NP_W    = (AVG_PERIODS > 1) ? $clog2(AVG_PERIODS) : 1;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic [NP_W-1:0]  nper_q;
  logic             window_done;
  logic             silence_hit;
  logic [2:0]       verdict;

  assign acc_next    = acc_q + ACC_W'(cnt_q) + ACC_W'(1);
  assign window_done = rise_i && armed_q && (nper_q == NP_W'(AVG_PERIODS - 1));
  assign silence_hit = !rise_i && (cnt_q == CNT_W'(TIMEOUT));
  assign verdict     = classify(64'(acc_next), CLK_HZ, AVG_PERIODS, GRP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      nper_q     <= '0;
      tone_ok_o  <= 1'b0;
      tone_idx_o <= 2'd0;
    end else if (rise_i) begin
      cnt_q <= '0;
      if (!armed_q) begin
        armed_q <= 1'b1;
        acc_q   <= '0;
        nper_q  <= '0;
      end else if (window_done) begin
        tone_ok_o <= verdict[2];
        if (verdict[2]) tone_idx_o <= verdict[1:0];
        acc_q  <= '0;
        nper_q <= '0;
      end else begin
        acc_q  <= acc_next;
        nper_q <= nper_q + NP_W'(1);
      end
    end else if (silence_hit) begin
      armed_q   <= 1'b0;
      tone_ok_o <= 1'b0;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    silence_hit |=> !tone_ok_o); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TIMEOUT)); // R8
  AST_OK_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_ok_o) |-> $past(rise_i)); // R2
  AST_IDX_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone_idx_o) |-> $past(rise_i)); // R3
endmodule

// File: rtl/dtmf_freq_decoder.sv
module dtmf_freq_decoder #(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned AVG_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_sq,
  input  logic       hi_sq,
  output logic       early_valid,
  output logic [3:0] code
);
  import dtmf_pkg::*;

  logic       lo_rise, hi_rise;
  logic       lo_ok, hi_ok;
  logic [1:0] lo_idx, hi_idx;
  logic       pair_ok;

  dtmf_sync_edge #(.SYNC_STAGES(2)) u_lo_sync (
    .clk(clk), .rst_n(rst_n), .sq_i(lo_sq), .rise_o(lo_rise));
  dtmf_sync_edge #(.SYNC_STAGES(2)) u_hi_sync (
    .clk(clk), .rst_n(rst_n), .sq_i(hi_sq), .rise_o(hi_rise));

  dtmf_period_meter #(.CLK_HZ(CLK_HZ), .AVG_PERIODS(AVG_PERIODS), .GRP(1'b0)) u_lo_meter (
    .clk(clk), .rst_n(rst_n), .rise_i(lo_rise), .tone_ok_o(lo_ok), .tone_idx_o(lo_idx));
  dtmf_period_meter #(.CLK_HZ(CLK_HZ), .AVG_PERIODS(AVG_PERIODS), .GRP(1'b1)) u_hi_meter (
    .clk(clk), .rst_n(rst_n), .rise_i(hi_rise), .tone_ok_o(hi_ok), .tone_idx_o(hi_idx));

  assign pair_ok = lo_ok & hi_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early_valid <= 1'b0;
      code        <= 4'd0;
    end else begin
      early_valid <= pair_ok;
      if (pair_ok) code <= key_code(lo_idx, hi_idx);
    end
  end

  AST_VALID_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |-> $past(lo_ok && hi_ok)); // R7
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pair_ok) |-> $stable(code)); // R9
  AST_FALL_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (early_valid && !pair_ok) |=> !early_valid); // R8
endmodule

// File: tb/dtmf_freq_decoder_tb_top.sv
module dtmf_freq_decoder_tb_top;
  localparam int unsigned CLK_HZ = 178977;
  localparam int unsigned AVG    = 4;
  localparam int VEC_N = 22;

  localparam int unsigned V_LO [VEC_N] = '{697,697,697,770,770,770,852,852,852,941,941,941,
                                           697,770,852,941, 708,926, 725,770,852,770};
  localparam int unsigned V_HI [VEC_N] = '{1209,1336,1477,1209,1336,1477,1209,1336,1477,1336,1209,1477,
                                           1633,1633,1633,1633, 1209,1659, 1336,1418,1698,0};
  localparam bit V_OK [VEC_N] = '{1,1,1,1,1,1,1,1,1,1,1,1, 1,1,1,1, 1,1, 0,0,0,0};
  localparam int V_CODE [VEC_N] = '{1,2,3,4,5,6,7,8,9,10,11,12, 13,14,15,0, 1,0, 0,0,0,0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_sq = 1'b0;
  logic hi_sq = 1'b0;
  logic early_valid;
  logic [3:0] code;

  int checks = 0;
  int errors = 0;
  int unsigned lo_p = 0;
  int unsigned hi_p = 0;
  int lo_ext_req = 0;
  int lo_ext_done = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtmf_freq_decoder #(.CLK_HZ(CLK_HZ), .AVG_PERIODS(AVG)) dut_i (
    .clk(clk), .rst_n(rst_n), .lo_sq(lo_sq), .hi_sq(hi_sq),
    .early_valid(early_valid), .code(code));

  function automatic int unsigned period_of(input int unsigned f);
    return (f == 0) ? 0 : (CLK_HZ + f / 2) / f;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : lo_gen
    forever begin
      if (lo_p == 0) begin
        lo_sq = 1'b0;
        @(negedge clk);
      end else begin
        int unsigned p;
        int extra;
        p = lo_p;
        extra = 0;
        if (lo_ext_req != lo_ext_done) begin
          extra = 14;
          lo_ext_done = lo_ext_req;
        end
        lo_sq = 1'b1;
        repeat (p / 2) @(negedge clk);
        lo_sq = 1'b0;
        repeat (p - p / 2 + extra) @(negedge clk);
      end
    end
  end

  initial begin : hi_gen
    forever begin
      if (hi_p == 0) begin
        hi_sq = 1'b0;
        @(negedge clk);
      end else begin
        int unsigned p;
        p = hi_p;
        hi_sq = 1'b1;
        repeat (p / 2) @(negedge clk);
        hi_sq = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int drops;
    repeat (5) @(negedge clk);
    chk(early_valid == 1'b0, "R1 valid in reset", early_valid, 0);
    chk(code == 4'd0, "R1 code in reset", code, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(early_valid == 1'b0, "R1 valid idle", early_valid, 0);
    chk(code == 4'd0, "R1 code idle", code, 0);

    // Table walk: R2 R3 R4 R5 R6 R7, silence gap R8
    for (int v = 0; v < VEC_N; v++) begin
      lo_p = period_of(V_LO[v]);
      hi_p = period_of(V_HI[v]);
      repeat (3000) @(negedge clk);
      if (V_OK[v]) begin
        chk(early_valid == 1'b1, $sformatf("R2 R3 R4 valid vec %0d", v), early_valid, 1);
        chk(code == 4'(V_CODE[v]), $sformatf("R6 code vec %0d", v), code, V_CODE[v]);
      end else begin
        chk(early_valid == 1'b0, $sformatf("R5 R7 reject vec %0d", v), early_valid, 0);
      end
      lo_p = 0;
      hi_p = 0;
      repeat (800) @(negedge clk);
      chk(early_valid == 1'b0, $sformatf("R8 gap vec %0d", v), early_valid, 0);
    end

    // R8 + R9: key 9, then high group goes silent
    lo_p = period_of(852);
    hi_p = period_of(1477);
    repeat (3000) @(negedge clk);
    chk(early_valid == 1'b1 && code == 4'd9, "R8 setup key 9", code, 9);
    hi_p = 0;
    repeat (100) @(negedge clk);
    chk(early_valid == 1'b1, "R8 not before timeout", early_valid, 1);
    repeat (400) @(negedge clk);
    chk(early_valid == 1'b0, "R8 falls after timeout", early_valid, 0);
    repeat (1000) @(negedge clk);
    chk(code == 4'd9, "R9 code held", code, 9);
    chk(early_valid == 1'b0, "R7 low group alone", early_valid, 0);
    lo_p = 0;
    repeat (800) @(negedge clk);

    // R10: one stretched low period
    lo_p = period_of(770);
    hi_p = period_of(1336);
    repeat (3000) @(negedge clk);
    chk(early_valid == 1'b1 && code == 4'd5, "R10 setup key 5", code, 5);
    lo_ext_req++;
    drops = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (!early_valid) drops++;
    end
    chk(drops == 0, "R10 stretched period tolerated", drops, 0);
    chk(code == 4'd5, "R10 code after stretch", code, 5);
    lo_p = 0;
    hi_p = 0;
    repeat (800) @(negedge clk);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule